// File: doc/BRIEF.md
# Oscillator Waveform Selector with Pulse Comparator

This block turns the phase of a 24-bit oscillator accumulator into a registered 12-bit waveform word. Four shapes can be switched in through a 4-bit select: a triangle, a sawtooth, a pulse and an externally supplied noise word. The triangle can be ring-modulated by a second oscillator's most significant bit. The pulse comes from a magnitude compare of the accumulator's top 12 bits against a pulse-width value. That compare is registered, so it reaches the output one cycle late. A test control holds the pulse term fully high.

When more than one shape is selected, the output is the bitwise AND of the selected shapes. This covers the pulse-gated sawtooth case: the sawtooth value appears only while the pulse is high. When the select is cleared, the output does not snap to zero. It keeps its last value for a programmable number of cycles and then drops to zero, which models a floating converter input that slowly discharges. Every output update is registered, so the output reflects the inputs sampled at the previous rising clock edge.

Top module: `wave_mixer`

## Requirements
- R1: While rst_n is low, wave_o is 0, and the internal pulse level and float timer are cleared.
- R2: With select 4'b0010 (select bit 1 = sawtooth only), wave_o after the next edge equals acc_i[23:12] of the sampled cycle. Accumulator bits 11..0 have no effect.
- R3: With select 4'b0001 (select bit 0 = triangle only), let f be the fold bit. If f is 1, wave_o = {~acc_i[22:12], 1'b0}. If f is 0, wave_o = {acc_i[22:12], 1'b0}. Bit 0 is always zero.
- R4: The fold bit f is acc_i[23] XOR ring_src_msb_i when ring_en_i is 1. It is acc_i[23] alone when ring_en_i is 0, and ring_src_msb_i then has no effect.
- R5: The pulse term (select bit 2) is 12'hFFF when acc_i[23:12] >= pw_i and 12'h000 otherwise. The comparison is registered, so a change to the compare result reaches wave_o one cycle later than a sawtooth change would.
- R6: While test_i is 1, the pulse term is 12'hFFF, whatever the pulse width and accumulator.
- R7: With select bit 3 (noise) alone, wave_o after the next edge equals noise_i.
- R8: With several select bits set, wave_o is the bitwise AND of the selected terms. For example, pulse plus sawtooth gives the sawtooth while the pulse is high and 0 while it is low.
- R9: When the select is 4'b0000, wave_o keeps its last value for FLOAT_CYCLES-1 edges. On the FLOAT_CYCLES-th consecutive edge that samples a zero select, it becomes 0, and it stays 0 after that.
- R10: Any edge that samples a nonzero select reloads the float timer to FLOAT_CYCLES. A later zero-select stretch therefore always gets the full hold time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_i | input | 24 | Oscillator accumulator phase |
| ring_src_msb_i | input | 1 | Most significant bit of the modulating oscillator |
| ring_en_i | input | 1 | Ring modulation enable for the triangle |
| test_i | input | 1 | Forces the pulse term high |
| pw_i | input | 12 | Pulse width compared with accumulator bits 23..12 |
| noise_i | input | 12 | Noise word from the noise generator |
| sel_i | input | 4 | Shape select: bit0 triangle, bit1 sawtooth, bit2 pulse, bit3 noise |
| wave_o | output | 12 | Registered waveform word |

## Verification
The sawtooth and the triangle are swept over all 4096 top-accumulator values, under every combination of ring enable and source bit. This catches a fold on the wrong bit, an inverted bit 0, or a ring input that leaks through while ring modulation is disabled. The pulse is swept at several widths, including the equality point where a design using a strict compare would output zero. A single-cycle accumulator step across the width then exposes a design that compares combinationally and so has no lag. Every nonzero select code is tried against mixed patterns, so a combination handled with OR or priority logic produces wrong bits. The float timer is exercised for the exact expiry edge and for reload after a brief reselect; an off-by-one timer or a timer that is not reloaded clears the output early or late.

// File: rtl/wave_mixer_pkg.sv
package wave_mixer_pkg;
    localparam int SEL_TRI   = 0;
    localparam int SEL_SAW   = 1;
    localparam int SEL_PULSE = 2;
    localparam int SEL_NOISE = 3;
    localparam int NUM_SRC   = 4;
endpackage

// File: rtl/wave_shaper.sv
module wave_shaper #(
    parameter int ACC_W = 24,
    parameter int OUT_W = 12
) (
    input  logic [ACC_W-1:0] acc_i,
    input  logic             flip_i,
    output logic [OUT_W-1:0] saw_o,
    output logic [OUT_W-1:0] tri_o
);
    logic [OUT_W-1:0] top;
    logic             fold;

    always_comb begin
        top   = acc_i[ACC_W-1 -: OUT_W];
        fold  = top[OUT_W-1] ^ flip_i;
        saw_o = top;
        tri_o = {(fold ? ~top[OUT_W-2:0] : top[OUT_W-2:0]), 1'b0};
    end
endmodule

// File: rtl/wave_pulse_cmp.sv
module wave_pulse_cmp #(
    parameter int ACC_W = 24,
    parameter int OUT_W = 12
) (
    input  logic [ACC_W-1:0] acc_i,
    input  logic [OUT_W-1:0] pw_i,
    output logic             ge_o
);
    always_comb ge_o = (acc_i[ACC_W-1 -: OUT_W] >= pw_i);
endmodule

// File: rtl/wave_combiner.sv
module wave_combiner #(
    parameter int OUT_W = 12,
    parameter int N_SRC = 4
) (
    input  logic [N_SRC-1:0][OUT_W-1:0] src_i,
    input  logic [N_SRC-1:0]            sel_i,
    output logic [OUT_W-1:0]            mix_o
);
    logic [N_SRC-1:0][OUT_W-1:0] masked;

    for (genvar g = 0; g < N_SRC; g++) begin : g_mask
        assign masked[g] = sel_i[g] ? src_i[g] : {OUT_W{1'b1}};
    end

    always_comb begin
        mix_o = {OUT_W{1'b1}};
        for (int i = 0; i < N_SRC; i++) mix_o = mix_o & masked[i];
    end
endmodule

// File: rtl/wave_mixer.sv
module wave_mixer
    import wave_mixer_pkg::*;
#(
    parameter int ACC_W        = 24,
    parameter int OUT_W        = 12,
    parameter int FLOAT_CYCLES = 1024
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] acc_i,
    input  logic             ring_src_msb_i,
    input  logic             ring_en_i,
    input  logic             test_i,
    input  logic [OUT_W-1:0] pw_i,
    input  logic [OUT_W-1:0] noise_i,
    input  logic [NUM_SRC-1:0] sel_i,
    output logic [OUT_W-1:0] wave_o
);
    localparam int TTL_W = $clog2(FLOAT_CYCLES + 1);

    typedef struct packed {
        logic [OUT_W-1:0] wave;
        logic             pulse;
        logic [TTL_W-1:0] ttl;
    } state_t;

    state_t state_d, state_q;

    logic [OUT_W-1:0]              saw_w, tri_w, pulse_w, mix_w;
    logic                          ge_w;
    logic [NUM_SRC-1:0][OUT_W-1:0] src_w;

    wave_shaper #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_shaper (
        .acc_i  (acc_i),
        .flip_i (ring_en_i & ring_src_msb_i),
        .saw_o  (saw_w),
        .tri_o  (tri_w)
    );

    wave_pulse_cmp #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_cmp (
        .acc_i (acc_i),
        .pw_i  (pw_i),
        .ge_o  (ge_w)
    );

    always_comb begin
        pulse_w          = {OUT_W{test_i | state_q.pulse}};
        src_w[SEL_TRI]   = tri_w;
        src_w[SEL_SAW]   = saw_w;
        src_w[SEL_PULSE] = pulse_w;
        src_w[SEL_NOISE] = noise_i;
    end

    wave_combiner #(.OUT_W(OUT_W), .N_SRC(NUM_SRC)) u_comb (
        .src_i (src_w),
        .sel_i (sel_i),
        .mix_o (mix_w)
    );

    always_comb begin
        state_d       = state_q;
        state_d.pulse = ge_w;
        if (sel_i != '0) begin
            state_d.wave = mix_w;
            state_d.ttl  = TTL_W'(FLOAT_CYCLES);
        end else if (state_q.ttl != '0) begin
            state_d.ttl = state_q.ttl - TTL_W'(1);
            if (state_q.ttl == TTL_W'(1)) state_d.wave = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign wave_o = state_q.wave;
endmodule

// File: rtl/wave_mixer_chk.sv
module wave_mixer_chk #(
    parameter int ACC_W = 24,
    parameter int OUT_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic [ACC_W-1:0] acc_i,
    input logic             test_i,
    input logic [OUT_W-1:0] noise_i,
    input logic [3:0]       sel_i,
    input logic [OUT_W-1:0] wave_o
);
    assert_reset_zero_R1: assert property (@(posedge clk)
        !rst_n |=> wave_o == '0);

    assert_saw_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sel_i == 4'b0010 |=> wave_o == $past(acc_i[ACC_W-1 -: OUT_W]));

    assert_pulse_levels_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sel_i == 4'b0100 |=> (wave_o == '0 || wave_o == '1));

    assert_test_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == 4'b0100 && test_i) |=> wave_o == '1);

    assert_noise_and_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sel_i[3] |=> (wave_o & ~$past(noise_i)) == '0);

    assert_float_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sel_i == 4'b0000 |=> (wave_o == '0 || $stable(wave_o)));
endmodule

bind wave_mixer wave_mixer_chk #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .acc_i   (acc_i),
    .test_i  (test_i),
    .noise_i (noise_i),
    .sel_i   (sel_i),
    .wave_o  (wave_o)
);

// File: tb/wave_mixer_tb.sv
module wave_mixer_tb;
    localparam int TTL = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] acc = '0;
    logic        src = 1'b0;
    logic        ren = 1'b0;
    logic        tst = 1'b0;
    logic [11:0] pw = '0;
    logic [11:0] noise = '0;
    logic [3:0]  sel = '0;
    logic [11:0] wave;

    int checks = 0;
    int fails  = 0;

    wave_mixer #(.FLOAT_CYCLES(TTL)) u_dut (
        .clk(clk), .rst_n(rst_n), .acc_i(acc), .ring_src_msb_i(src),
        .ring_en_i(ren), .test_i(tst), .pw_i(pw), .noise_i(noise),
        .sel_i(sel), .wave_o(wave)
    );

    always #10 clk = ~clk;

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [11:0] exp);
        checks++;
        if (wave !== exp) begin
            fails++;
            $display("FAIL %s: actual %03h expected %03h", req, wave, exp);
        end
    endtask

    function automatic logic [11:0] tri_m(input logic [11:0] t, input logic f);
        logic [10:0] lo;
        lo = (t[11] ^ f) ? ~t[10:0] : t[10:0];
        return {lo, 1'b0};
    endfunction

    function automatic logic [11:0] mix_m(input logic [3:0] s, input logic [23:0] a,
                                          input logic [11:0] p, input logic [11:0] n);
        logic [11:0] r;
        r = 12'hFFF;
        if (s[0]) r &= tri_m(a[23:12], 1'b0);
        if (s[1]) r &= a[23:12];
        if (s[2]) r &= (a[23:12] >= p) ? 12'hFFF : 12'h000;
        if (s[3]) r &= n;
        return r;
    endfunction

    initial begin
        #(20 * 200000);
        fails++;
        checks++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [11:0] held;
        sel = 4'b0010;
        acc = 24'hABC123;
        @(negedge clk);
        step();
        chk("R1 reset", 12'h000);
        rst_n = 1'b1;

        // R2 sawtooth sweep, low bits varied
        sel = 4'b0010;
        for (int v = 0; v < 4096; v++) begin
            acc = {v[11:0], v[11:0] ^ 12'h5A5};
            step();
            chk("R2 saw", v[11:0]);
        end

        // R3/R4 triangle sweep with ring enable and source bit
        sel = 4'b0001;
        for (int m = 0; m < 4; m++) begin
            ren = m[1];
            src = m[0];
            for (int v = 0; v < 4096; v++) begin
                acc = {v[11:0], 12'h3C7};
                step();
                if (m[1]) chk("R4 ring", tri_m(v[11:0], m[0]));
                else      chk("R3 tri", tri_m(v[11:0], 1'b0));
            end
        end
        ren = 1'b0;
        src = 1'b0;

        // R5 pulse sweep, each value held two cycles
        sel = 4'b0100;
        for (int k = 0; k < 5; k++) begin
            pw = (k == 0) ? 12'h000 : (k == 4) ? 12'hFFF : 12'(k * 1000);
            for (int v = 0; v < 4096; v += 41) begin
                acc = {v[11:0], 12'h000};
                step();
                step();
                chk("R5 pulse", (v[11:0] >= pw) ? 12'hFFF : 12'h000);
            end
            acc = {pw, 12'hFFF};
            step();
            step();
            chk("R5 pulse equal", 12'hFFF);
        end

        // R5 one-cycle lag
        pw = 12'h800;
        acc = 24'h900000;
        step();
        step();
        chk("R5 lag high", 12'hFFF);
        acc = 24'h100000;
        step();
        chk("R5 lag still high", 12'hFFF);
        step();
        chk("R5 lag now low", 12'h000);
        acc = 24'h800000;
        step();
        chk("R5 lag still low", 12'h000);
        step();
        chk("R5 lag rises", 12'hFFF);

        // R6 test forces pulse high
        pw = 12'hFFF;
        acc = 24'h001000;
        step();
        step();
        chk("R6 pre", 12'h000);
        tst = 1'b1;
        step();
        chk("R6 test", 12'hFFF);
        step();
        chk("R6 test held", 12'hFFF);
        tst = 1'b0;
        step();
        chk("R6 release", 12'h000);

        // R7 noise only
        sel = 4'b1000;
        for (int v = 0; v < 4096; v += 7) begin
            noise = v[11:0] ^ 12'h9C3;
            step();
            chk("R7 noise", v[11:0] ^ 12'h9C3);
        end

        // R8 every nonzero select code
        for (int s = 1; s < 16; s++) begin
            for (int p = 0; p < 6; p++) begin
                sel = s[3:0];
                acc = 24'(p * 24'h2B7319 + 24'h13579);
                pw = 12'(p * 12'h2A3);
                noise = 12'(12'hF0F ^ (p * 12'h155));
                step();
                step();
                chk("R8 combine", mix_m(s[3:0], acc, pw, noise));
            end
        end

        // R9 float hold and decay
        sel = 4'b0010;
        acc = 24'h5A3000;
        step();
        chk("R9 setup", 12'h5A3);
        sel = 4'b0000;
        acc = 24'h123000;
        for (int j = 1; j < TTL; j++) begin
            step();
            chk("R9 hold", 12'h5A3);
        end
        step();
        chk("R9 decay", 12'h000);
        step();
        step();
        chk("R9 stays zero", 12'h000);

        // R10 reload after brief reselect
        sel = 4'b0010;
        acc = 24'h777000;
        step();
        sel = 4'b0000;
        for (int j = 0; j < 4; j++) step();
        sel = 4'b0010;
        acc = 24'h3E1000;
        step();
        held = 12'h3E1;
        sel = 4'b0000;
        for (int j = 1; j < TTL; j++) begin
            step();
            chk("R10 reload hold", held);
        end
        step();
        chk("R10 decay", 12'h000);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule